// File: doc/BRIEF.md
# Dual-Address DMA Channel Engine

This block is one DMA channel that copies data units from a source address to a destination address. Each unit takes two bus phases. The first phase reads the unit from the source into an internal holding register. The second phase writes that register to the destination. The channel drives a simple request/response memory port. A request is held until the memory answers with a one-cycle `mem_ack`, and in a read phase the memory returns `mem_rdata` in that same cycle.

Software sets up a run by placing the settings on the configuration inputs and pulsing `ctl_load` while the channel is idle. The settings are the start addresses, the unit count, the block length, the unit width, the stepping of each side, the transfer mode and the reload option. The pulse captures all of them and enables the channel.

A software pulse or a hardware request then starts a run. In single mode a run moves one unit. In successive mode it moves every remaining unit. In block mode it moves one block. Two active-low strobes report progress: one marks an accepted trigger and the other marks the final write of a run. A one-cycle done pulse reports that the count is used up.

Top module: `dmac_channel`

## Requirements
- R1: Each unit is a read at the current source address, then a write of exactly the returned word to the current destination address. The write request is presented in the cycle after the read is acknowledged. Address and direction stay stable until each request is acknowledged.
- R2: Width code 0, 1 and 2 selects units of 1, 2 and 4 bytes, and `mem_size` carries that code on every access. Code 3 acts as 4 bytes, with `mem_size` = 2.
- R3: Each side has its own address mode, applied after each unit's write completes. Code 1 adds the unit byte count, code 2 subtracts it, and codes 0 and 3 leave the address unchanged.
- R4: Transfer mode 0 (single) moves one unit per accepted trigger. Mode 3 behaves as mode 0.
- R5: Transfer mode 1 (successive) moves all remaining units of the count on one trigger.
- R6: Transfer mode 2 (block) moves the lesser of the block length and the remaining count on one trigger. A block length of 0 acts as 1.
- R7: With reload set in mode 1 or 2, both addresses return to their loaded start values when a run ends. Without reload, or in single mode, the addresses keep advancing across runs.
- R8: A trigger is `sw_trig` or `hw_req` high at a clock edge. Triggers have no effect while the channel is disabled.
- R9: `ack_n` is low for exactly one cycle per accepted trigger, namely the first cycle of that run's first read.
- R10: `end_n` is low exactly while the final write of a run is on the bus, and high at all other times.
- R11: The unit count falls by one per unit. When it reaches zero, the channel disables itself and `done_irq` is high for the single cycle after that last write is acknowledged. Later triggers are ignored until the next load.
- R12: A trigger that arrives during a run, including in the cycle the run's last write completes, is held and starts a new run right after. A trigger in the cycle where the count reaches zero is discarded.
- R13: After reset the bus is idle, both strobes are high and `done_irq` is low. `ctl_load` takes effect only while idle, and a loaded count of zero leaves the channel disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_load | input | 1 | Capture configuration and enable when idle |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Number of units |
| cfg_blk | input | BW | Block length in units |
| cfg_width | input | 2 | Unit width code |
| cfg_src_mode | input | 2 | Source stepping code |
| cfg_dst_mode | input | 2 | Destination stepping code |
| cfg_xmode | input | 2 | Transfer mode code |
| cfg_reload | input | 1 | Reload addresses at end of run |
| sw_trig | input | 1 | Software trigger |
| hw_req | input | 1 | Hardware trigger request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| ack_n | output | 1 | Trigger accepted strobe, active low |
| end_n | output | 1 | Final access of run strobe, active low |
| done_irq | output | 1 | Count exhausted pulse |

## Verification
Two events can land in the same cycle: a new trigger, and the completion of the write that ends a run. The bench waits until the final write is on the bus with `end_n` low and `mem_ack` high, then raises `hw_req` for exactly that cycle. When the count is not yet zero, that trigger must start the following run with one more `ack_n` pulse and the expected addresses. When the same cycle also drains the count, the trigger must vanish: no further access, no extra acknowledge, and a single done pulse.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } dmac_state_e;

   localparam logic [1:0] XM_SINGLE = 2'd0;
   localparam logic [1:0] XM_SUCC   = 2'd1;
   localparam logic [1:0] XM_BLOCK  = 2'd2;

   localparam logic [1:0] AM_FIXED  = 2'd0;
   localparam logic [1:0] AM_INC    = 2'd1;
   localparam logic [1:0] AM_DEC    = 2'd2;

   function automatic logic [2:0] unit_bytes(input logic [1:0] wcode);
      case (wcode)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] size_code(input logic [1:0] wcode);
      return (wcode == 2'd3) ? 2'd2 : wcode;
   endfunction

endpackage

// File: rtl/dmac_addr_unit.sv
`timescale 1ns/1ps
module dmac_addr_unit
   import dmac_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic [1:0]    mode,
   input  logic [2:0]    bytes,
   input  logic          adv,
   input  logic          rld,
   output logic [AW-1:0] cur
);

   logic [AW-1:0] start_q;
   logic [AW-1:0] cur_q;
   logic [AW-1:0] step;

   assign step = AW'(bytes);
   assign cur  = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         cur_q   <= '0;
      end else if (load) begin
         start_q <= load_val;
         cur_q   <= load_val;
      end else if (adv) begin
         if (rld) begin
            cur_q <= start_q;
         end else begin
            case (mode)
               AM_INC:  cur_q <= cur_q + step;
               AM_DEC:  cur_q <= cur_q - step;
               default: cur_q <= cur_q;
            endcase
         end
      end
   end

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !rld && !load && mode == AM_INC) |=> (cur == $past(cur) + AW'($past(bytes)))); // R3
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !rld && !load && mode == AM_DEC) |=> (cur == $past(cur) - AW'($past(bytes)))); // R3
   AST_HOLD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(adv && (rld || mode == AM_INC || mode == AM_DEC))) |=> $stable(cur)); // R3
   AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && rld && !load) |=> (cur == start_q)); // R7

endmodule

// File: rtl/dmac_trig_latch.sv
`timescale 1ns/1ps
module dmac_trig_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic idle_ok,
   input  logic kill,
   input  logic trig_in,
   output logic fire,
   output logic pend
);

   logic pend_q;

   assign pend = pend_q;
   assign fire = idle_ok && en && (pend_q || trig_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (!en || kill) begin
         pend_q <= 1'b0;
      end else if (fire) begin
         pend_q <= 1'b0;
      end else if (trig_in) begin
         pend_q <= 1'b1;
      end
   end

   AST_NO_PEND_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> !pend_q); // R8
   AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !pend_q); // R12
   AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && en && !kill && !fire) |=> pend_q); // R12

endmodule

// File: rtl/dmac_channel.sv
`timescale 1ns/1ps
module dmac_channel
   import dmac_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_load,
   input  logic [AW-1:0] cfg_src,
   input  logic [AW-1:0] cfg_dst,
   input  logic [CW-1:0] cfg_count,
   input  logic [BW-1:0] cfg_blk,
   input  logic [1:0]    cfg_width,
   input  logic [1:0]    cfg_src_mode,
   input  logic [1:0]    cfg_dst_mode,
   input  logic [1:0]    cfg_xmode,
   input  logic          cfg_reload,
   input  logic          sw_trig,
   input  logic          hw_req,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          ack_n,
   output logic          end_n,
   output logic          done_irq
);

   localparam int NSIDE = 2;
   localparam logic [CW-1:0] ONE = CW'(1);

   if (DW != 32) begin : g_bad_dw
      $error("dmac_channel: DW must be 32 to carry the widest unit");
   end
   if (BW > CW) begin : g_bad_bw
      $error("dmac_channel: block length wider than count");
   end
   if (AW < 4 || CW < 1 || BW < 1) begin : g_bad_small
      $error("dmac_channel: width parameter too small");
   end

   dmac_state_e   state_q;
   logic [DW-1:0] hold_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] left_q;
   logic          en_q;
   logic [1:0]    width_q;
   logic [1:0]    xmode_q;
   logic [1:0]    smode_q;
   logic [1:0]    dmode_q;
   logic [BW-1:0] blk_q;
   logic          reload_q;
   logic          ack_n_q;
   logic          done_q;

   logic          idle;
   logic          load_ok;
   logic          wr_done;
   logic          last_unit;
   logic          cnt_last;
   logic          fire;
   logic          pend;
   logic          kill;
   logic          rld;
   logic [CW-1:0] blk_eff;
   logic [CW-1:0] run_len;
   logic [2:0]    step_bytes;

   logic [AW-1:0] side_ld [NSIDE];
   logic [1:0]    side_md [NSIDE];
   logic [AW-1:0] side_cur [NSIDE];

   assign idle       = (state_q == ST_IDLE);
   assign load_ok    = ctl_load && idle;
   assign wr_done    = (state_q == ST_WR) && mem_ack;
   assign last_unit  = (left_q == ONE);
   assign cnt_last   = (cnt_q == ONE);
   assign kill       = (wr_done && last_unit && cnt_last) || load_ok;
   assign rld        = wr_done && last_unit && reload_q &&
                       (xmode_q == XM_SUCC || xmode_q == XM_BLOCK);
   assign step_bytes = unit_bytes(width_q);
   assign blk_eff    = (blk_q == '0) ? ONE : CW'(blk_q);

   always_comb begin
      case (xmode_q)
         XM_SUCC:  run_len = cnt_q;
         XM_BLOCK: run_len = (blk_eff < cnt_q) ? blk_eff : cnt_q;
         default:  run_len = ONE;
      endcase
   end

   dmac_trig_latch u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .idle_ok (idle && !ctl_load),
      .kill    (kill),
      .trig_in (sw_trig || hw_req),
      .fire    (fire),
      .pend    (pend)
   );

   assign side_ld[0] = cfg_src;
   assign side_ld[1] = cfg_dst;
   assign side_md[0] = smode_q;
   assign side_md[1] = dmode_q;

   for (genvar g = 0; g < NSIDE; g++) begin : g_side
      dmac_addr_unit #(.AW(AW)) u_addr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load_ok),
         .load_val (side_ld[g]),
         .mode     (side_md[g]),
         .bytes    (step_bytes),
         .adv      (wr_done),
         .rld      (rld),
         .cur      (side_cur[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         hold_q   <= '0;
         cnt_q    <= '0;
         left_q   <= '0;
         en_q     <= 1'b0;
         width_q  <= 2'd0;
         xmode_q  <= XM_SINGLE;
         smode_q  <= AM_FIXED;
         dmode_q  <= AM_FIXED;
         blk_q    <= '0;
         reload_q <= 1'b0;
         ack_n_q  <= 1'b1;
         done_q   <= 1'b0;
      end else begin
         ack_n_q <= 1'b1;
         done_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (load_ok) begin
                  cnt_q    <= cfg_count;
                  en_q     <= (cfg_count != '0);
                  width_q  <= cfg_width;
                  xmode_q  <= cfg_xmode;
                  smode_q  <= cfg_src_mode;
                  dmode_q  <= cfg_dst_mode;
                  blk_q    <= cfg_blk;
                  reload_q <= cfg_reload;
               end else if (fire) begin
                  left_q  <= run_len;
                  ack_n_q <= 1'b0;
                  state_q <= ST_RD;
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  hold_q  <= mem_rdata;
                  state_q <= ST_WR;
               end
            end
            ST_WR: begin
               if (mem_ack) begin
                  cnt_q  <= cnt_q - ONE;
                  left_q <= left_q - ONE;
                  if (last_unit) begin
                     state_q <= ST_IDLE;
                     if (cnt_last) begin
                        en_q   <= 1'b0;
                        done_q <= 1'b1;
                     end
                  end else begin
                     state_q <= ST_RD;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = !idle;
   assign mem_we    = (state_q == ST_WR);
   assign mem_addr  = (state_q == ST_WR) ? side_cur[1] : side_cur[0];
   assign mem_size  = size_code(width_q);
   assign mem_wdata = hold_q;
   assign ack_n     = ack_n_q;
   assign end_n     = !((state_q == ST_WR) && last_unit);
   assign done_irq  = done_q;

   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we)); // R1
   AST_WDATA_FROM_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (mem_wdata == $past(mem_rdata))); // R1
   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_size != 2'd3); // R2
   AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n) |=> ack_n); // R9
   AST_ACK_AT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n) |-> (mem_req && !mem_we)); // R9
   AST_END_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!end_n) |-> (mem_req && mem_we)); // R10
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> (!mem_req && !en_q)); // R11
   AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_load && mem_req && !mem_ack) |=> $stable(cnt_q)); // R13

endmodule

// File: tb/dmac_channel_tb.sv
`timescale 1ns/100ps
module dmac_channel_tb;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CW = 8;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_load = 1'b0;
   logic [AW-1:0] cfg_src = '0;
   logic [AW-1:0] cfg_dst = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [BW-1:0] cfg_blk = '0;
   logic [1:0]    cfg_width = '0;
   logic [1:0]    cfg_src_mode = '0;
   logic [1:0]    cfg_dst_mode = '0;
   logic [1:0]    cfg_xmode = '0;
   logic          cfg_reload = 1'b0;
   logic          sw_trig = 1'b0;
   logic          hw_req = 1'b0;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_size;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic          mem_ack = 1'b0;
   logic          ack_n;
   logic          end_n;
   logic          done_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit slow = 1'b0;

   logic [31:0] exp_sa [0:127];
   logic [31:0] exp_da [0:127];
   bit          exp_last [0:127];
   int          n_exp = 0;
   int          rp = 0;
   int          wp = 0;
   int          n_ackn = 0;
   int          n_done = 0;
   int          exp_runs = 0;
   bit          exp_done = 1'b0;
   logic [1:0]  exp_size = 2'd0;

   always #2.5 clk = ~clk;

   dmac_channel #(.AW(AW), .DW(DW), .CW(CW), .BW(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_blk(cfg_blk),
      .cfg_width(cfg_width), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
      .cfg_xmode(cfg_xmode), .cfg_reload(cfg_reload), .sw_trig(sw_trig), .hw_req(hw_req),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .ack_n(ack_n), .end_n(end_n), .done_irq(done_irq)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h5A00_00C3;
   endfunction

   function automatic logic [31:0] stepf(input logic [31:0] a, input int md, input int b);
      if (md == 1) return a + 32'(b);
      if (md == 2) return a - 32'(b);
      return a;
   endfunction

   assign mem_rdata = pat(mem_addr);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exv);
      end
   endtask

   // memory responder: optional one-cycle stall on each access
   initial begin
      bit waited;
      waited = 1'b0;
      forever begin
         @(negedge clk);
         #0.5;
         if (mem_req) begin
            if (slow && !waited) begin
               mem_ack = 1'b0;
               waited = 1'b1;
            end else begin
               mem_ack = 1'b1;
               waited = 1'b0;
            end
         end else begin
            mem_ack = 1'b0;
            waited = 1'b0;
         end
      end
   end

   // bus monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (!ack_n) n_ackn++;
         if (done_irq) n_done++;
         if (mem_req && mem_ack) begin
            if (!mem_we) begin
               if (rp >= n_exp) begin
                  chk(1'b0, "R11", "unexpected read", mem_addr, 32'hFFFF_FFFF);
               end else begin
                  chk(mem_addr == exp_sa[rp], "R3", "read address", mem_addr, exp_sa[rp]);
                  chk(mem_size == exp_size, "R2", "read size", 32'(mem_size), 32'(exp_size));
                  rp++;
               end
            end else begin
               if (wp >= n_exp) begin
                  chk(1'b0, "R11", "unexpected write", mem_addr, 32'hFFFF_FFFF);
               end else begin
                  chk(mem_addr == exp_da[wp], "R3", "write address", mem_addr, exp_da[wp]);
                  chk(mem_wdata == pat(exp_sa[wp]), "R1", "write data", mem_wdata, pat(exp_sa[wp]));
                  chk(end_n == !exp_last[wp], "R10", "end strobe", 32'(end_n), 32'(!exp_last[wp]));
                  chk(mem_size == exp_size, "R2", "write size", 32'(mem_size), 32'(exp_size));
                  wp++;
               end
            end
         end else if (!end_n) begin
            chk(mem_req && mem_we && wp < n_exp && exp_last[wp], "R10", "end strobe outside final write",
                32'(end_n), 32'd1);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic model(input logic [31:0] s0, input logic [31:0] d0, input int w,
                        input int sm, input int dm, input int xm, input int blk,
                        input int cnt, input bit rl, input int ntrig);
      int rem;
      int len;
      int b;
      logic [31:0] sa;
      logic [31:0] da;
      rem = cnt;
      sa = s0;
      da = d0;
      b = (w == 0) ? 1 : (w == 1) ? 2 : 4;
      exp_size = (w == 3) ? 2'd2 : 2'(w);
      rp = 0; wp = 0; n_exp = 0; n_ackn = 0; n_done = 0; exp_runs = 0;
      for (int t = 0; t < ntrig; t++) begin
         if (rem == 0) break;
         exp_runs++;
         if (xm == 1) len = rem;
         else if (xm == 2) len = (blk == 0) ? 1 : blk;
         else len = 1;
         if (len > rem) len = rem;
         for (int i = 0; i < len; i++) begin
            exp_sa[n_exp] = sa;
            exp_da[n_exp] = da;
            exp_last[n_exp] = (i == len - 1);
            n_exp++;
            sa = stepf(sa, sm, b);
            da = stepf(da, dm, b);
            rem--;
         end
         if (rl && (xm == 1 || xm == 2)) begin
            sa = s0;
            da = d0;
         end
      end
      exp_done = (rem == 0) && (cnt != 0);
   endtask

   task automatic load_cfg(input logic [31:0] s, input logic [31:0] d, input int w,
                           input int sm, input int dm, input int xm, input int blk,
                           input int cnt, input bit rl);
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_width = 2'(w);
      cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm); cfg_xmode = 2'(xm);
      cfg_blk = BW'(blk); cfg_count = CW'(cnt); cfg_reload = rl;
      ctl_load = 1'b1;
      @(negedge clk);
      ctl_load = 1'b0;
   endtask

   task automatic pulse_sw;
      @(negedge clk);
      sw_trig = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0;
   endtask

   task automatic pulse_hw;
      @(negedge clk);
      hw_req = 1'b1;
      @(negedge clk);
      hw_req = 1'b0;
   endtask

   task automatic wait_quiet;
      int q;
      q = 0;
      while (q < 4) begin
         @(negedge clk);
         #1.5;
         if (mem_req) q = 0;
         else q++;
      end
   endtask

   // raise hw_req for exactly the cycle in which a run's final write completes
   task automatic hw_on_final_write;
      bit hit;
      hit = 1'b0;
      while (!hit) begin
         @(negedge clk);
         #1.2;
         hit = mem_req && mem_we && !end_n && mem_ack;
      end
      hw_req = 1'b1;
      @(negedge clk);
      hw_req = 1'b0;
   endtask

   task automatic end_case(input string tag);
      wait_quiet();
      chk(rp == n_exp, tag, "read count", 32'(rp), 32'(n_exp));
      chk(wp == n_exp, tag, "write count", 32'(wp), 32'(n_exp));
      chk(n_ackn == exp_runs, "R9", "ack strobes", 32'(n_ackn), 32'(exp_runs));
      chk(n_done == int'(exp_done), "R11", "done pulses", 32'(n_done), 32'(exp_done));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R13: reset state
      chk(mem_req == 1'b0, "R13", "reset mem_req", 32'(mem_req), 32'd0);
      chk(ack_n == 1'b1, "R13", "reset ack_n", 32'(ack_n), 32'd1);
      chk(end_n == 1'b1, "R13", "reset end_n", 32'(end_n), 32'd1);
      chk(done_irq == 1'b0, "R13", "reset done", 32'(done_irq), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8: trigger before any load is ignored
      model(32'h0, 32'h0, 0, 0, 0, 0, 0, 0, 1'b0, 1);
      pulse_sw();
      end_case("R8");

      // R1 R2 R3 R5 R10: sweep widths and both stepping modes, successive mode
      for (int w = 0; w < 3; w++) begin
         for (int sm = 0; sm < 3; sm++) begin
            for (int dm = 0; dm < 3; dm++) begin
               slow = ((w + sm + dm) % 2) == 1;
               load_cfg(32'h1000, 32'h2000, w, sm, dm, 1, 0, 3, 1'b0);
               model(32'h1000, 32'h2000, w, sm, dm, 1, 0, 3, 1'b0, 1);
               pulse_sw();
               end_case("R5");
            end
         end
      end
      slow = 1'b0;

      // R2 R3: width code 3 acts as 4 bytes, mode code 3 holds
      load_cfg(32'h3000, 32'h4000, 3, 3, 2, 1, 0, 2, 1'b0);
      model(32'h3000, 32'h4000, 3, 3, 2, 1, 0, 2, 1'b0, 1);
      pulse_hw();
      end_case("R2");

      // R4 R7: single mode, reload has no effect, one unit per trigger
      load_cfg(32'h5000, 32'h6000, 1, 1, 1, 0, 0, 3, 1'b1);
      model(32'h5000, 32'h6000, 1, 1, 1, 0, 0, 3, 1'b1, 4);
      for (int k = 1; k <= 3; k++) begin
         pulse_sw();
         wait_quiet();
         chk(wp == k, "R4", "units after single trigger", 32'(wp), 32'(k));
      end
      // R11: fourth trigger after count exhausted is ignored
      pulse_sw();
      end_case("R11");

      // R4: transfer mode 3 acts as single
      load_cfg(32'h5100, 32'h6100, 2, 1, 1, 3, 3, 2, 1'b0);
      model(32'h5100, 32'h6100, 2, 1, 1, 3, 3, 2, 1'b0, 1);
      pulse_sw();
      end_case("R4");

      // R6 R7: block mode with reload, runs of 2,2,1
      slow = 1'b1;
      load_cfg(32'h7000, 32'h8000, 0, 1, 2, 2, 2, 5, 1'b1);
      model(32'h7000, 32'h8000, 0, 1, 2, 2, 2, 5, 1'b1, 3);
      for (int k = 0; k < 3; k++) begin
         pulse_hw();
         wait_quiet();
      end
      end_case("R7");
      slow = 1'b0;

      // R7: block mode without reload keeps advancing
      load_cfg(32'h7100, 32'h8100, 1, 1, 1, 2, 2, 4, 1'b0);
      model(32'h7100, 32'h8100, 1, 1, 1, 2, 2, 4, 1'b0, 2);
      pulse_sw();
      wait_quiet();
      pulse_sw();
      end_case("R7");

      // R6: block length 0 acts as 1
      load_cfg(32'h7200, 32'h8200, 2, 1, 1, 2, 0, 2, 1'b0);
      model(32'h7200, 32'h8200, 2, 1, 1, 2, 0, 2, 1'b0, 1);
      pulse_sw();
      end_case("R6");

      // R12: trigger in the final-write cycle and one mid-run are both kept
      load_cfg(32'h9000, 32'hA000, 2, 1, 1, 2, 2, 6, 1'b0);
      model(32'h9000, 32'hA000, 2, 1, 1, 2, 2, 6, 1'b0, 3);
      pulse_hw();
      hw_on_final_write();
      while (n_ackn < 2) @(negedge clk);
      pulse_hw();
      end_case("R12");

      // R12 R11: trigger in the cycle the count reaches zero is discarded
      load_cfg(32'h9100, 32'hA100, 0, 1, 1, 2, 2, 2, 1'b0);
      model(32'h9100, 32'hA100, 0, 1, 1, 2, 2, 2, 1'b0, 2);
      pulse_hw();
      hw_on_final_write();
      end_case("R12");
      pulse_sw();
      end_case("R11");

      // R13: load while running is ignored
      load_cfg(32'hB000, 32'hC000, 2, 1, 1, 1, 0, 4, 1'b0);
      model(32'hB000, 32'hC000, 2, 1, 1, 1, 0, 4, 1'b0, 1);
      pulse_sw();
      while (!(mem_req && mem_we)) @(negedge clk);
      cfg_src = 32'hDEAD_0000;
      cfg_count = CW'(9);
      ctl_load = 1'b1;
      @(negedge clk);
      ctl_load = 1'b0;
      end_case("R13");

      // R13: zero count leaves the channel disabled
      load_cfg(32'hB100, 32'hC100, 0, 1, 1, 1, 0, 0, 1'b0);
      model(32'hB100, 32'hC100, 0, 1, 1, 1, 0, 0, 1'b0, 1);
      pulse_sw();
      end_case("R13");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule